// File: doc/BRIEF.md
# Stream Identifier Span Filter

This block decides, one transaction at a time, whether a transaction tagged with a stream identifier should be counted by a performance counter. Each candidate arrives with a valid strobe and its identifier. One clock later the block returns a single-cycle match pulse. The pulse is high only when the strobe was present and the identifier passed the filter.

The filter holds a match pattern and a mode flag. Both are loaded through a write port. The mode flag is taken from the event-type configuration word. In exact mode every implemented identifier bit must equal the pattern. In span mode the pattern encodes its own ignore field: the lowest zero of the pattern marks the top of that field, and every bit below that zero is a one. The zero bit and all bits beneath it are then don't-care. All higher bits must still match the identifier.

A separate enable input turns filtering off. While it is low, every identifier passes. The identifier width is a parameter, and pattern bits above that width have no effect.

Top module: `sid_span_filter`

## Requirements
- R1: After reset, `match_pulse` is low. The stored settings are span mode with an all-ones pattern, so the first strobe after reset matches any identifier.
- R2: `match_pulse` rises in the cycle after a cycle with `in_valid` high and a passing identifier. It lasts one cycle per strobe, and it is low in the cycle after any cycle with `in_valid` low.
- R3: In exact mode (span flag 0), an identifier matches only if all SID_W bits equal the low SID_W bits of the pattern.
- R4: In span mode, let the lowest zero of the pattern be bit k. Identifier bits k down to 0 are ignored. For example, pattern 0x0042 matches 0x0042 and 0x0043, and pattern 0x0013 matches 0x0010 through 0x0017.
- R5: In span mode, identifier bits above the lowest pattern zero must equal the pattern. Pattern 0x0042 rejects 0x0040, 0x0044 and 0x0142.
- R6: In span mode, a pattern whose implemented bits are all ones has no terminating zero, and it matches every identifier.
- R7: While `filt_en` is low, every strobe matches, whatever the stored pattern and mode.
- R8: On a write, the span flag is bit 29 of `cfg_evtype`. All other bits of that word, including the event number in bits 15:0, have no effect on filtering.
- R9: Pattern bits at and above SID_W are ignored. With SID_W = 16, pattern 0xFFFF0042 in exact mode matches identifier 0x0042.
- R10: A write takes effect for strobes from the next cycle onward. A strobe presented in the same cycle as the write is judged with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the pattern and span flag |
| cfg_evtype | input | CFG_W | Event-type word; bit SPAN_BIT selects span mode |
| cfg_pattern | input | CFG_W | Match pattern; low SID_W bits are used |
| filt_en | input | 1 | Filtering enable; low passes everything |
| in_valid | input | 1 | Transaction strobe |
| in_sid | input | SID_W | Stream identifier of the transaction |
| match_pulse | output | 1 | Registered one-cycle match result |

## Verification
Exact mode is tried with equal identifiers and with identifiers that differ only in the lowest bit. This shows that no bit is ignored. Span patterns with ignore fields of one bit and of three bits are tried at the lower and upper edges of the covered range, and one step outside each edge. These tests show whether the boundary is found at the right zero and whether the bits above it are still compared. An all-ones pattern, a disabled filter and a pattern with junk above the implemented width separate the three match-all paths from real comparison. A strobe presented in the same cycle as a write shows which settings are used for that strobe.

// File: rtl/sid_span_filter.sv
module sid_span_filter #(
  parameter int SID_W    = 16,
  parameter int CFG_W    = 32,
  parameter int SPAN_BIT = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_evtype,
  input  logic [CFG_W-1:0] cfg_pattern,
  input  logic             filt_en,
  input  logic             in_valid,
  input  logic [SID_W-1:0] in_sid,
  output logic             match_pulse
);

  localparam logic [SID_W-1:0] ALL_ONES = {SID_W{1'b1}};

  logic [SID_W-1:0] pat_q;
  logic             span_q;
  logic [SID_W-1:0] zero_oh, dc_mask, care_mask;
  logic             hit;
  logic             unused_cfg;

  assign unused_cfg = ^{cfg_evtype, cfg_pattern};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= ALL_ONES;
      span_q <= 1'b1;
    end else if (cfg_we) begin
      pat_q  <= cfg_pattern[SID_W-1:0];
      span_q <= cfg_evtype[SPAN_BIT];
    end
  end

  // lowest zero of the pattern as a one-hot; zero when the pattern is all ones
  assign zero_oh   = ~pat_q & (pat_q + 1'b1);
  assign dc_mask   = (zero_oh == '0) ? ALL_ONES : (zero_oh | (zero_oh - 1'b1));
  assign care_mask = !filt_en ? '0 : (span_q ? ~dc_mask : ALL_ONES);
  assign hit       = ((in_sid ^ pat_q) & care_mask) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_pulse <= 1'b0;
    else        match_pulse <= in_valid & hit;
  end

endmodule

// File: rtl/sid_span_filter_chk.sv
module sid_span_filter_chk #(
  parameter int SID_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             filt_en,
  input logic             in_valid,
  input logic [SID_W-1:0] in_sid,
  input logic [SID_W-1:0] pat_q,
  input logic             span_q,
  input logic             match_pulse
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !match_pulse);

  assert_bypass_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !filt_en) |=> match_pulse);

  assert_exact_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && filt_en && !span_q && in_sid == pat_q) |=> match_pulse);

  assert_exact_differ_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && filt_en && !span_q && in_sid != pat_q) |=> !match_pulse);

  assert_span_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && filt_en && span_q && in_sid == pat_q) |=> match_pulse);

  assert_span_allones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && filt_en && span_q && (&pat_q)) |=> match_pulse);

endmodule

bind sid_span_filter sid_span_filter_chk #(.SID_W(SID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .in_valid(in_valid),
  .in_sid(in_sid), .pat_q(pat_q), .span_q(span_q), .match_pulse(match_pulse)
);

// File: tb/sid_span_filter_tb_top.sv
module sid_span_filter_tb_top;
  localparam int SID_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_evtype = '0;
  logic [31:0] cfg_pattern = '0;
  logic filt_en = 1'b1;
  logic in_valid = 1'b0;
  logic [SID_W-1:0] in_sid = '0;
  logic match_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [SID_W-1:0] m_pat = '1;
  logic m_span = 1'b1;

  always #4 clk = ~clk;

  sid_span_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_evtype(cfg_evtype),
    .cfg_pattern(cfg_pattern), .filt_en(filt_en), .in_valid(in_valid),
    .in_sid(in_sid), .match_pulse(match_pulse)
  );

  function automatic bit model(logic [SID_W-1:0] sid, logic [SID_W-1:0] pat,
                               bit span, bit en);
    int k;
    if (!en) return 1'b1;
    if (!span) return sid == pat;
    k = -1;
    for (int i = SID_W - 1; i >= 0; i--) if (!pat[i]) k = i;
    if (k < 0) return 1'b1;
    for (int i = k + 1; i < SID_W; i++) if (sid[i] != pat[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: match_pulse=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] ev, logic [31:0] pat);
    @(negedge clk);
    cfg_we = 1'b1; cfg_evtype = ev; cfg_pattern = pat;
    @(negedge clk);
    cfg_we = 1'b0;
    m_pat = pat[SID_W-1:0];
    m_span = ev[29];
  endtask

  task automatic probe(logic [SID_W-1:0] sid, string req);
    @(negedge clk);
    in_valid = 1'b1; in_sid = sid;
    @(negedge clk);
    in_valid = 1'b0;
    check(match_pulse, model(sid, m_pat, m_span, filt_en), req);
    @(negedge clk);
    check(match_pulse, 1'b0, {req, " pulse ends R2"});
  endtask

  task automatic t_reset();
    check(match_pulse, 1'b0, "R1 reset low");
    probe(16'h1234, "R1 default match-all");
  endtask

  task automatic t_exact();
    write_cfg(32'h0000_0001, 32'h0000_0042);
    probe(16'h0042, "R3 equal");
    probe(16'h0043, "R3 low bit differs");
    probe(16'h8042, "R3 top bit differs");
  endtask

  task automatic t_span();
    write_cfg(32'h2000_0000, 32'h0000_0042);
    probe(16'h0042, "R4 span 0x42 self");
    probe(16'h0043, "R4 span 0x43");
    probe(16'h0040, "R5 span 0x40");
    probe(16'h0044, "R5 span 0x44");
    probe(16'h0142, "R5 span 0x142");
    write_cfg(32'h2000_0000, 32'h0000_0013);
    probe(16'h0010, "R4 wide low edge");
    probe(16'h0017, "R4 wide high edge");
    probe(16'h0018, "R5 wide above");
    probe(16'h000F, "R5 wide below");
  endtask

  task automatic t_allones();
    write_cfg(32'h2000_0000, 32'h0000_FFFF);
    probe(16'h0000, "R6 all-ones zero id");
    probe(16'hA5C3, "R6 all-ones any id");
  endtask

  task automatic t_disabled();
    write_cfg(32'h0000_0000, 32'h0000_0042);
    filt_en = 1'b0;
    probe(16'h7777, "R7 disabled");
    filt_en = 1'b1;
    probe(16'h7777, "R7 re-enabled rejects");
  endtask

  task automatic t_evtype();
    write_cfg(32'hDFFF_FFFF, 32'h0000_0042);
    probe(16'h0043, "R8 other bits keep exact");
    write_cfg(32'h2000_0000, 32'h0000_0042);
    probe(16'h0043, "R8 bit29 selects span");
  endtask

  task automatic t_width();
    write_cfg(32'h0000_0000, 32'hFFFF_0042);
    probe(16'h0042, "R9 high pattern bits ignored");
  endtask

  task automatic t_same_cycle();
    write_cfg(32'h0000_0000, 32'h0000_0042);
    @(negedge clk);
    cfg_we = 1'b1; cfg_evtype = 32'h0; cfg_pattern = 32'h0000_0010;
    in_valid = 1'b1; in_sid = 16'h0042;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check(match_pulse, 1'b1, "R10 same-cycle uses old");
    m_pat = 16'h0010; m_span = 1'b0;
    probe(16'h0010, "R10 new settings next");
  endtask

  initial begin
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exact();
    t_span();
    t_allones();
    t_disabled();
    t_evtype();
    t_width();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule